// File: doc/BRIEF.md
# Prefetch and Write-Posting FIFO Engine

This block sits between a 32-bit host register port and a 16-bit flash data path. It smooths transfers in both directions through one 64-byte buffer. In read mode the engine pulls a programmed number of bytes from the flash side as halfwords. It stores them so that the host can collect them as 32-bit words. In write mode the host pushes 32-bit words, and the engine sends them to the flash side one halfword at a time.

Software starts a transfer with a single command that carries the direction, the byte length, a threshold and a DMA flag. If a start arrives while a transfer is still open, the engine refuses it, and software can then fall back to direct access. While a transfer runs, the engine reports two things: a fill figure whose meaning depends on the direction, and the number of bytes still to cross the flash side. It raises two sticky events: one when the fill figure rises to the threshold, and one when the remaining count reaches zero. It can also request DMA service. A stop command closes the transfer and clears everything.

Top module: `prefetch_post_engine`

## Requirements
- R1: After reset the engine is idle: busy=0, fifo_count=0, remain=0, evt_status=0, irq=0, dma_req=0, h_rd_valid=0, h_wr_ready=0.
- R2: A start pulse while idle opens a transfer on the next clock edge. busy goes to 1 and remain takes cfg_len. cfg_len is a nonzero multiple of 4. cfg_dir=0 selects read and cfg_dir=1 selects write. fifo_count then reads 0 in read mode and 64 in write mode.
- R3: A start pulse while busy is refused. start_refused is 1 for exactly the cycle after that pulse, and the open transfer keeps its direction, length and progress.
- R4: In read mode the engine takes one halfword per cycle from the flash side while fl_rd_ready and fl_rd_valid are both high. remain falls by 2 for each halfword, and fetching stops once remain is 0. Each host word is {second halfword, first halfword}.
- R5: In read mode fifo_count is the number of stored bytes. fl_rd_ready is low while 64 bytes are held, and h_rd_valid is low while fewer than 4 bytes are held.
- R6: In write mode fifo_count is the number of free bytes. Each accepted host word goes to the flash side low halfword first. h_wr_ready is low while fewer than 4 bytes are free, and also once cfg_len bytes have been accepted.
- R7: In write mode remain falls by 2 for each halfword sent to the flash side, so it reaches 0 only when the buffer is empty.
- R8: evt_status bit 0 (threshold event) is set on the edge after fifo_count rises from below the threshold to at least the threshold.
- R9: evt_status bit 1 (count event) is set on the edge where remain drops to 0.
- R10: Writing 1 to a bit of evt_clr clears that status bit. irq is the OR of evt_status AND evt_en, and evt_en does not gate the status bits themselves.
- R11: dma_req is high when the DMA flag is set and fifo_count is at least the threshold. In write mode it also requires host bytes still to be accepted.
- R12: A stop pulse returns the engine to the reset state of R1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start command pulse |
| stop | input | 1 | Stop and clear command pulse |
| cfg_dir | input | 1 | Direction: 0 read, 1 write |
| cfg_dma | input | 1 | Enable DMA requests |
| cfg_thresh | input | 7 | Threshold in bytes |
| cfg_len | input | 16 | Transfer length in bytes |
| busy | output | 1 | Transfer open |
| start_refused | output | 1 | Start was refused (one cycle) |
| fifo_count | output | 7 | Stored bytes (read) or free bytes (write) |
| remain | output | 16 | Bytes still to cross the flash side |
| evt_en | input | 2 | Interrupt enables: bit0 threshold, bit1 count |
| evt_clr | input | 2 | Write-1-to-clear for evt_status |
| evt_status | output | 2 | Sticky events: bit0 threshold, bit1 count |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | DMA service request |
| h_rd_valid | output | 1 | Host read word available |
| h_rd_ready | input | 1 | Host takes read word |
| h_rd_data | output | 32 | Host read word |
| h_wr_valid | input | 1 | Host write word offered |
| h_wr_ready | output | 1 | Engine accepts write word |
| h_wr_data | input | 32 | Host write word |
| fl_rd_valid | input | 1 | Flash halfword offered |
| fl_rd_ready | output | 1 | Engine accepts flash halfword |
| fl_rd_data | input | 16 | Flash read halfword |
| fl_wr_valid | output | 1 | Halfword offered to flash |
| fl_wr_ready | input | 1 | Flash takes halfword |
| fl_wr_data | output | 16 | Flash write halfword |

## Verification
The bench moves the flash source in exact numbers of cycles. It checks that the threshold event stays clear one halfword below the threshold and appears just after the crossing; an engine that compared with the wrong sign would fire early or never. Reads longer than the buffer check that fetching pauses at 64 bytes and resumes once one word is taken. A design that overflowed would lose halfwords or report a count that wraps. Writes check that h_wr_ready drops both when space runs out and when the length is used up. An engine that counted remaining bytes on host acceptance would flag completion while data still sat in the buffer. A start issued during a transfer must be refused without disturbing the transfer. Write-1-to-clear has to touch only the addressed status bit.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

  localparam int unsigned EVT_THR = 0;
  localparam int unsigned EVT_CNT = 1;
endpackage

// File: rtl/ppe_hwfifo.sv
module ppe_hwfifo #(
  parameter int unsigned DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic [1:0]               push_n,
  input  logic [31:0]              push_data,
  input  logic [1:0]               pop_n,
  output logic [31:0]              head_data,
  output logic [$clog2(DEPTH):0]   level
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;

  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [AW-1:0] wp1, rp1;

  assign wp1 = wp_q + AW'(1);
  assign rp1 = rp_q + AW'(1);
  assign head_data = {mem[rp1], mem[rp_q]};
  assign level = lvl_q;

  always_comb begin
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      wp_d  = wp_q + AW'(push_n);
      rp_d  = rp_q + AW'(pop_n);
      lvl_d = lvl_q + LW'(push_n) - LW'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!clr && push_n != 2'd0) mem[wp_q] <= push_data[15:0];
    if (!clr && push_n == 2'd2) mem[wp1]  <= push_data[31:16];
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (8'(lvl_q) + 8'(push_n)) <= 8'(DEPTH))
    else $error("fifo overflow");

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    8'(pop_n) <= 8'(lvl_q))
    else $error("fifo underflow");
endmodule

// File: rtl/ppe_ctrl.sv
module ppe_ctrl
  import ppe_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned LEN_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          stop,
  input  logic                          cfg_dir,
  input  logic                          cfg_dma,
  input  logic [$clog2(FIFO_BYTES):0]   cfg_thresh,
  input  logic [LEN_W-1:0]              cfg_len,
  input  logic [$clog2(FIFO_BYTES/2):0] level,
  input  logic [31:0]                   head_data,
  input  logic                          h_rd_ready,
  input  logic                          h_wr_valid,
  input  logic [31:0]                   h_wr_data,
  input  logic                          fl_rd_valid,
  input  logic [15:0]                   fl_rd_data,
  input  logic                          fl_wr_ready,
  output logic                          active,
  output dir_e                          dir,
  output logic                          dma_on,
  output logic [$clog2(FIFO_BYTES):0]   thr,
  output logic [LEN_W-1:0]              remain,
  output logic [$clog2(FIFO_BYTES):0]   fifo_count,
  output logic                          host_left_nz,
  output logic                          last_beat,
  output logic                          start_refused,
  output logic [1:0]                    push_n,
  output logic [31:0]                   push_data,
  output logic [1:0]                    pop_n,
  output logic                          h_rd_valid,
  output logic                          h_wr_ready,
  output logic                          fl_rd_ready,
  output logic                          fl_wr_valid,
  output logic [15:0]                   fl_wr_data
);
  localparam int unsigned DEPTH = FIFO_BYTES / 2;
  localparam int unsigned LW    = $clog2(DEPTH) + 1;
  localparam int unsigned CW    = $clog2(FIFO_BYTES) + 1;

  logic             active_q, active_d;
  dir_e             dir_q, dir_d;
  logic             dma_q, dma_d;
  logic [CW-1:0]    thr_q, thr_d;
  logic [LEN_W-1:0] remain_q, remain_d;
  logic [LEN_W-1:0] hleft_q, hleft_d;
  logic             refused_q, refused_d;
  logic             cfg_en, start_ok;
  logic             is_rd, is_wr;
  logic             rd_hs, wr_hs, frd_hs, fwr_hs, fl_beat;
  logic [CW-1:0]    fill_bytes;

  assign is_rd = active_q && (dir_q == DIR_READ);
  assign is_wr = active_q && (dir_q == DIR_WRITE);
  assign fill_bytes = {level, 1'b0};

  assign h_rd_valid  = is_rd && (level >= LW'(2));
  assign h_wr_ready  = is_wr && ((LW'(DEPTH) - level) >= LW'(2)) && (hleft_q != '0);
  assign fl_rd_ready = is_rd && (remain_q != '0) && (level < LW'(DEPTH));
  assign fl_wr_valid = is_wr && (level != '0);
  assign fl_wr_data  = head_data[15:0];

  assign rd_hs   = h_rd_valid && h_rd_ready;
  assign wr_hs   = h_wr_valid && h_wr_ready;
  assign frd_hs  = fl_rd_valid && fl_rd_ready;
  assign fwr_hs  = fl_wr_valid && fl_wr_ready;
  assign fl_beat = frd_hs || fwr_hs;

  always_comb begin
    push_n    = 2'd0;
    push_data = h_wr_data;
    pop_n     = 2'd0;
    if (frd_hs) begin
      push_n    = 2'd1;
      push_data = {16'h0000, fl_rd_data};
    end else if (wr_hs) begin
      push_n = 2'd2;
    end
    if (rd_hs)       pop_n = 2'd2;
    else if (fwr_hs) pop_n = 2'd1;
  end

  always_comb begin
    if (!active_q)  fifo_count = '0;
    else if (is_wr) fifo_count = CW'(FIFO_BYTES) - fill_bytes;
    else            fifo_count = fill_bytes;
  end

  assign start_ok  = start && !active_q && !stop;
  assign cfg_en    = start_ok || stop;
  assign last_beat = fl_beat && (remain_q == LEN_W'(2));

  always_comb begin
    active_d  = active_q;
    dir_d     = dir_q;
    dma_d     = dma_q;
    thr_d     = thr_q;
    remain_d  = remain_q;
    hleft_d   = hleft_q;
    refused_d = start && active_q && !stop;
    if (stop) begin
      active_d = 1'b0;
      dir_d    = DIR_READ;
      dma_d    = 1'b0;
      thr_d    = '0;
      remain_d = '0;
      hleft_d  = '0;
    end else if (start_ok) begin
      active_d = 1'b1;
      dir_d    = dir_e'(cfg_dir);
      dma_d    = cfg_dma;
      thr_d    = cfg_thresh;
      remain_d = cfg_len;
      hleft_d  = cfg_dir ? cfg_len : '0;
    end else begin
      if (fl_beat) remain_d = remain_q - LEN_W'(2);
      if (wr_hs)   hleft_d  = hleft_q - LEN_W'(4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      dir_q     <= DIR_READ;
      dma_q     <= 1'b0;
      thr_q     <= '0;
      remain_q  <= '0;
      hleft_q   <= '0;
      refused_q <= 1'b0;
    end else begin
      active_q  <= active_d;
      refused_q <= refused_d;
      remain_q  <= remain_d;
      hleft_q   <= hleft_d;
      if (cfg_en) begin
        dir_q <= dir_d;
        dma_q <= dma_d;
        thr_q <= thr_d;
      end
    end
  end

  assign active        = active_q;
  assign dir           = dir_q;
  assign dma_on        = dma_q;
  assign thr           = thr_q;
  assign remain        = remain_q;
  assign host_left_nz  = (hleft_q != '0);
  assign start_refused = refused_q;

  p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active_q && !stop) |=> (start_refused && active_q &&
      dir_q == $past(dir_q) && thr_q == $past(thr_q)))
    else $error("busy start not refused cleanly");

  p_remain_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !stop) |=> (remain_q <= $past(remain_q)))
    else $error("remaining count grew during transfer");

  p_write_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && remain_q == '0) |-> (level == '0))
    else $error("remaining count zero with data still buffered");
endmodule

// File: rtl/ppe_events.sv
module ppe_events
  import ppe_pkg::*;
#(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          stop,
  input  dir_e          dir,
  input  logic          dma_on,
  input  logic [CW-1:0] thr,
  input  logic [CW-1:0] fifo_count,
  input  logic          host_left_nz,
  input  logic          last_beat,
  input  logic [1:0]    evt_en,
  input  logic [1:0]    evt_clr,
  output logic [1:0]    status,
  output logic          irq,
  output logic          dma_req
);
  logic       above_now, above_q, above_d;
  logic [1:0] status_q, status_d, set_v;

  assign above_now = active && (fifo_count >= thr);

  always_comb begin
    set_v          = 2'b00;
    set_v[EVT_THR] = above_now && !above_q;
    set_v[EVT_CNT] = last_beat;
    if (stop) begin
      status_d = 2'b00;
      above_d  = 1'b0;
    end else begin
      status_d = (status_q & ~evt_clr) | set_v;
      above_d  = above_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 2'b00;
      above_q  <= 1'b0;
    end else begin
      status_q <= status_d;
      above_q  <= above_d;
    end
  end

  assign status  = status_q;
  assign irq     = |(status_q & evt_en);
  assign dma_req = dma_on && above_now && ((dir == DIR_READ) || host_left_nz);

  p_thr_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (above_now && !above_q && !stop) |=> status_q[EVT_THR])
    else $error("threshold crossing not recorded");
endmodule

// File: rtl/prefetch_post_engine.sv
module prefetch_post_engine
  import ppe_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned LEN_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        stop,
  input  logic                        cfg_dir,
  input  logic                        cfg_dma,
  input  logic [$clog2(FIFO_BYTES):0] cfg_thresh,
  input  logic [LEN_W-1:0]            cfg_len,
  output logic                        busy,
  output logic                        start_refused,
  output logic [$clog2(FIFO_BYTES):0] fifo_count,
  output logic [LEN_W-1:0]            remain,
  input  logic [1:0]                  evt_en,
  input  logic [1:0]                  evt_clr,
  output logic [1:0]                  evt_status,
  output logic                        irq,
  output logic                        dma_req,
  output logic                        h_rd_valid,
  input  logic                        h_rd_ready,
  output logic [31:0]                 h_rd_data,
  input  logic                        h_wr_valid,
  output logic                        h_wr_ready,
  input  logic [31:0]                 h_wr_data,
  input  logic                        fl_rd_valid,
  output logic                        fl_rd_ready,
  input  logic [15:0]                 fl_rd_data,
  output logic                        fl_wr_valid,
  input  logic                        fl_wr_ready,
  output logic [15:0]                 fl_wr_data
);
  localparam int unsigned DEPTH = FIFO_BYTES / 2;
  localparam int unsigned LW    = $clog2(DEPTH) + 1;
  localparam int unsigned CW    = $clog2(FIFO_BYTES) + 1;

  logic [LW-1:0] level;
  logic [31:0]   head_data;
  logic [1:0]    push_n, pop_n;
  logic [31:0]   push_data;
  logic          active, dma_on, host_left_nz, last_beat;
  dir_e          dir;
  logic [CW-1:0] thr;

  ppe_hwfifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (stop),
    .push_n    (push_n),
    .push_data (push_data),
    .pop_n     (pop_n),
    .head_data (head_data),
    .level     (level)
  );

  ppe_ctrl #(.FIFO_BYTES(FIFO_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .stop          (stop),
    .cfg_dir       (cfg_dir),
    .cfg_dma       (cfg_dma),
    .cfg_thresh    (cfg_thresh),
    .cfg_len       (cfg_len),
    .level         (level),
    .head_data     (head_data),
    .h_rd_ready    (h_rd_ready),
    .h_wr_valid    (h_wr_valid),
    .h_wr_data     (h_wr_data),
    .fl_rd_valid   (fl_rd_valid),
    .fl_rd_data    (fl_rd_data),
    .fl_wr_ready   (fl_wr_ready),
    .active        (active),
    .dir           (dir),
    .dma_on        (dma_on),
    .thr           (thr),
    .remain        (remain),
    .fifo_count    (fifo_count),
    .host_left_nz  (host_left_nz),
    .last_beat     (last_beat),
    .start_refused (start_refused),
    .push_n        (push_n),
    .push_data     (push_data),
    .pop_n         (pop_n),
    .h_rd_valid    (h_rd_valid),
    .h_wr_ready    (h_wr_ready),
    .fl_rd_ready   (fl_rd_ready),
    .fl_wr_valid   (fl_wr_valid),
    .fl_wr_data    (fl_wr_data)
  );

  ppe_events #(.CW(CW)) u_evt (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (active),
    .stop         (stop),
    .dir          (dir),
    .dma_on       (dma_on),
    .thr          (thr),
    .fifo_count   (fifo_count),
    .host_left_nz (host_left_nz),
    .last_beat    (last_beat),
    .evt_en       (evt_en),
    .evt_clr      (evt_clr),
    .status       (evt_status),
    .irq          (irq),
    .dma_req      (dma_req)
  );

  assign busy      = active;
  assign h_rd_data = head_data;

  p_count_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active && $past(remain) != '0 && remain == '0)
      |-> evt_status[EVT_CNT])
    else $error("count event missing when remaining count drained");

  p_dma_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (busy && fifo_count >= thr))
    else $error("dma request without threshold data or space");

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop) |-> (!busy && fifo_count == '0 && remain == '0 && evt_status == 2'b00))
    else $error("stop did not clear the engine");
endmodule

// File: tb/prefetch_post_engine_bench.sv
module prefetch_post_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, stop, cfg_dir, cfg_dma;
  logic [6:0]  cfg_thresh;
  logic [15:0] cfg_len;
  logic        busy, start_refused;
  logic [6:0]  fifo_count;
  logic [15:0] remain;
  logic [1:0]  evt_en, evt_clr, evt_status;
  logic        irq, dma_req;
  logic        h_rd_valid, h_rd_ready;
  logic [31:0] h_rd_data;
  logic        h_wr_valid, h_wr_ready;
  logic [31:0] h_wr_data;
  logic        fl_rd_valid, fl_rd_ready;
  logic [15:0] fl_rd_data;
  logic        fl_wr_valid, fl_wr_ready;
  logic [15:0] fl_wr_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic        src_on, snk_on;
  logic [15:0] src_idx;
  int          snk_idx;
  logic [15:0] snk_mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fl_rd_valid = src_on;
  assign fl_rd_data  = 16'hA000 + src_idx;
  assign fl_wr_ready = snk_on;

  always @(posedge clk) begin
    if (fl_rd_valid && fl_rd_ready) src_idx <= src_idx + 16'd1;
    if (fl_wr_valid && fl_wr_ready) begin
      if (snk_idx < 16) snk_mem[snk_idx] <= fl_wr_data;
      snk_idx <= snk_idx + 1;
    end
  end

  prefetch_post_engine u_prefetch_post_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cfg_dir(cfg_dir), .cfg_dma(cfg_dma), .cfg_thresh(cfg_thresh), .cfg_len(cfg_len),
    .busy(busy), .start_refused(start_refused), .fifo_count(fifo_count), .remain(remain),
    .evt_en(evt_en), .evt_clr(evt_clr), .evt_status(evt_status), .irq(irq), .dma_req(dma_req),
    .h_rd_valid(h_rd_valid), .h_rd_ready(h_rd_ready), .h_rd_data(h_rd_data),
    .h_wr_valid(h_wr_valid), .h_wr_ready(h_wr_ready), .h_wr_data(h_wr_data),
    .fl_rd_valid(fl_rd_valid), .fl_rd_ready(fl_rd_ready), .fl_rd_data(fl_rd_data),
    .fl_wr_valid(fl_wr_valid), .fl_wr_ready(fl_wr_ready), .fl_wr_data(fl_wr_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_xfer(input logic d, input logic dma, input logic [6:0] th, input logic [15:0] len);
    start = 1'b1; cfg_dir = d; cfg_dma = dma; cfg_thresh = th; cfg_len = len;
    cycles(1);
    start = 1'b0;
  endtask

  task automatic stop_xfer();
    stop = 1'b1;
    cycles(1);
    stop = 1'b0;
  endtask

  task automatic host_read(input string req, input logic [31:0] exp);
    chk(req, "h_rd_valid", 32'(h_rd_valid), 32'd1);
    chk(req, "h_rd_data", h_rd_data, exp);
    h_rd_ready = 1'b1;
    cycles(1);
    h_rd_ready = 1'b0;
  endtask

  task automatic host_write(input string req, input logic [31:0] data);
    chk(req, "h_wr_ready", 32'(h_wr_ready), 32'd1);
    h_wr_valid = 1'b1; h_wr_data = data;
    cycles(1);
    h_wr_valid = 1'b0;
  endtask

  task automatic run_src(input int n);
    src_on = 1'b1;
    cycles(n);
    src_on = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "fifo_count", 32'(fifo_count), 0);
    chk("R1", "remain", 32'(remain), 0);
    chk("R1", "status/irq/dma", {28'd0, evt_status, irq, dma_req}, 0);
    chk("R1", "host handshakes", {30'd0, h_rd_valid, h_wr_ready}, 0);
  endtask

  task automatic t_read_basic();
    src_idx = 16'd0;
    evt_en = 2'b11;
    start_xfer(1'b0, 1'b1, 7'd8, 16'd16);
    chk("R2", "busy", 32'(busy), 1);
    chk("R2", "remain", 32'(remain), 16);
    chk("R2", "read count", 32'(fifo_count), 0);
    chk("R5", "h_rd_valid empty", 32'(h_rd_valid), 0);
    run_src(3);
    chk("R5", "count 3 hw", 32'(fifo_count), 6);
    chk("R4", "remain 3 hw", 32'(remain), 10);
    chk("R8", "no thr evt below", 32'(evt_status[0]), 0);
    chk("R11", "no dma below", 32'(dma_req), 0);
    run_src(1);
    chk("R11", "dma at thr", 32'(dma_req), 1);
    cycles(1);
    chk("R8", "thr evt after cross", 32'(evt_status[0]), 1);
    run_src(10);
    chk("R4", "fetch stops at len", 32'(src_idx), 8);
    chk("R4", "remain zero", 32'(remain), 0);
    chk("R4", "fl_rd_ready low", 32'(fl_rd_ready), 0);
    chk("R9", "count evt", 32'(evt_status), 3);
    chk("R10", "irq", 32'(irq), 1);
    start = 1'b1; cfg_len = 16'd40; cfg_dir = 1'b1;
    cycles(1);
    start = 1'b0;
    chk("R3", "start_refused", 32'(start_refused), 1);
    chk("R3", "remain kept", 32'(remain), 0);
    chk("R3", "read count kept", 32'(fifo_count), 16);
    cycles(1);
    chk("R3", "refused one cycle", 32'(start_refused), 0);
    for (int i = 0; i < 4; i++)
      host_read("R4", {16'hA000 + 16'(2*i+1), 16'hA000 + 16'(2*i)});
    chk("R5", "drained count", 32'(fifo_count), 0);
    chk("R5", "h_rd_valid drained", 32'(h_rd_valid), 0);
    evt_clr = 2'b01;
    cycles(1);
    evt_clr = 2'b00;
    chk("R10", "w1c bit0 only", 32'(evt_status), 2);
    evt_en = 2'b01;
    #1;
    chk("R10", "irq masked", 32'(irq), 0);
    chk("R10", "status unmasked", 32'(evt_status), 2);
    evt_en = 2'b11;
    stop_xfer();
    chk("R12", "busy", 32'(busy), 0);
    chk("R12", "remain/count", {9'd0, fifo_count, remain}, 0);
    chk("R12", "status/irq", {29'd0, evt_status, irq}, 0);
  endtask

  task automatic t_read_backpressure();
    src_idx = 16'd0;
    start_xfer(1'b0, 1'b0, 7'd32, 16'd80);
    run_src(40);
    chk("R5", "full count", 32'(fifo_count), 64);
    chk("R5", "fl_rd_ready full", 32'(fl_rd_ready), 0);
    chk("R4", "remain paused", 32'(remain), 16);
    host_read("R5", 32'hA001_A000);
    chk("R5", "count after pop", 32'(fifo_count), 60);
    chk("R5", "fl_rd_ready resumed", 32'(fl_rd_ready), 1);
    run_src(2);
    chk("R5", "refilled", 32'(fifo_count), 64);
    chk("R4", "remain resumed", 32'(remain), 12);
    stop_xfer();
  endtask

  task automatic t_write_basic();
    snk_idx = 0;
    start_xfer(1'b1, 1'b1, 7'd24, 16'd12);
    chk("R2", "write count", 32'(fifo_count), 64);
    chk("R2", "remain", 32'(remain), 12);
    chk("R11", "dma write space", 32'(dma_req), 1);
    cycles(1);
    chk("R8", "thr evt write", 32'(evt_status), 1);
    host_write("R6", 32'h1111_2222);
    host_write("R6", 32'h3333_4444);
    host_write("R6", 32'h5555_6666);
    chk("R6", "free count", 32'(fifo_count), 52);
    chk("R6", "len exhausted", 32'(h_wr_ready), 0);
    chk("R11", "no dma when len done", 32'(dma_req), 0);
    chk("R7", "remain waits flash", 32'(remain), 12);
    snk_on = 1'b1;
    cycles(3);
    chk("R7", "remain half", 32'(remain), 6);
    chk("R9", "no count evt yet", 32'(evt_status[1]), 0);
    cycles(3);
    snk_on = 1'b0;
    chk("R7", "remain drained", 32'(remain), 0);
    chk("R7", "empty", 32'(fifo_count), 64);
    chk("R9", "count evt write", 32'(evt_status[1]), 1);
    chk("R6", "flash order", {snk_mem[0], snk_mem[1]}, 32'h2222_1111);
    chk("R6", "flash order", {snk_mem[4], snk_mem[5]}, 32'h6666_5555);
    chk("R6", "flash beats", 32'(snk_idx), 6);
    stop_xfer();
  endtask

  task automatic t_write_full();
    start_xfer(1'b1, 1'b0, 7'd24, 16'd80);
    for (int i = 0; i < 16; i++) host_write("R6", 32'(i));
    chk("R6", "full free", 32'(fifo_count), 0);
    chk("R6", "h_wr_ready full", 32'(h_wr_ready), 0);
    chk("R7", "remain untouched", 32'(remain), 80);
    snk_on = 1'b1;
    cycles(2);
    snk_on = 1'b0;
    chk("R6", "free after drain", 32'(fifo_count), 4);
    chk("R6", "h_wr_ready again", 32'(h_wr_ready), 1);
    chk("R7", "remain after drain", 32'(remain), 76);
    stop_xfer();
    chk("R12", "idle after write", {31'd0, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 0; stop = 0; cfg_dir = 0; cfg_dma = 0;
    cfg_thresh = '0; cfg_len = '0; evt_en = 2'b11; evt_clr = 2'b00;
    h_rd_ready = 0; h_wr_valid = 0; h_wr_data = '0;
    src_on = 0; snk_on = 0;
    src_idx = '0; snk_idx = 0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_read_basic();
    t_read_backpressure();
    t_write_basic();
    t_write_full();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule